// File: doc/BRIEF.md
# Up/Down Timer with Event Capture

A 16-bit general-purpose timer that counts up or down on a selectable time base and sits on a simple peripheral bus. The control register sets the count direction, free-running or periodic behaviour, a prescaler and one of four time bases. In periodic mode the counter reloads from the load register each time it runs out. In free-running mode it wraps. Each run-out sets a status flag. That flag drives the interrupt line until software acknowledges it.

Sixteen event inputs can latch the running count into a capture register. The control register enables this and picks which event is watched. A second status flag marks a fresh capture and clears when software reads the capture register. Software reads the count through a two-stage pipeline, so a read sees the count of two cycles earlier. Periodic mode can also restart the count when software acknowledges the interrupt. A load-register write that lands in a run-out cycle is held back until that cycle is over.

Top module: `udt_timer`

## Requirements
- R1: After synchronous reset the control register reads 0x000A. The load, value, capture and status registers read 0x0000, and `irq` is low.
- R2: Byte offsets: load 0x00 (read/write), value 0x04 (read-only), control 0x08 (read/write), acknowledge 0x0C (write-only, reads 0), capture 0x10 (read-only), status 0x1C (read-only). Any other offset reads 0. Control bits [15:13] always read 0. Read data appears on `bus_rdata` one cycle after the read and holds until the next read.
- R3: With control bit 2 = 0 the count falls by one per step. A step taken at 0 is a run-out.
- R4: With control bit 2 = 1 the count rises by one per step. A step taken at 0xFFFF is a run-out.
- R5: With control bit 3 = 1 (periodic), a run-out loads the count from the load register. With bit 3 = 0 the count wraps (0 to 0xFFFF, or 0xFFFF to 0).
- R6: Control bit 4 enables counting. Control bits [1:0] = 0, 1, 2, 3 make one step per 1, 16, 256 or 32768 time-base ticks. While bit 4 is 0 the count holds.
- R7: Control bits [6:5] pick the time base. 0 gives a tick every bus clock. 1, 2 and 3 give a tick per rising edge of `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. Each edge passes a two-flop synchronizer, so a rising edge first sampled at clock edge k can step the count at edge k+2.
- R8: A run-out sets status bit 0, and `irq` follows that bit. Writing 0x0C with data bit 0 = 1 clears it. A run-out in the same cycle wins.
- R9: In periodic mode with control bit 7 = 1, an acknowledge write with data bit 0 = 1 also loads the count from the load register and restarts the prescaler. With bit 7 = 0 the acknowledge write leaves the count alone.
- R10: A load write in a run-out cycle does not change the load register in that cycle, and the reload uses the old value. The written value lands in the first later cycle without a run-out, unless a newer load write replaces it first.
- R11: When control bit 12 = 1 and the event input chosen by control bits [11:8] is high in a cycle, the count of that cycle is latched into the capture register and status bit 1 is set. Reading the capture register clears status bit 1 unless a capture happens in the same cycle.
- R12: The value register returns the count as it stood two cycles before the read was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_clk | input | 3 | Alternative time bases, asynchronous |
| events | input | 16 | Capture event inputs, synchronous to clk |
| irq | output | 1 | Run-out interrupt, high while status bit 0 is set |

## Verification
The bench aims at the collision cycles. One is a load write in the very cycle of a periodic run-out. A design without deferral would reload the new value, or lose the write altogether. Another is an acknowledge that meets a run-out. A wrong priority there lets `irq` drop although a run-out just happened. A third is a capture read that meets a new capture. A wrong priority there loses the capture flag. The bench also counts the exact cycle of each prescaled step, both across the 32768 divider and through the synchronized external time bases. An off-by-one in the prescaler limit, or an extra synchronizer stage, then shows up as a miscompare of the value register. That register is itself checked for its two-cycle lag against the reference.

// File: rtl/udt_pkg.sv
package udt_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 5;
    localparam int N_EVT  = 16;
    localparam int N_SRC  = 3;
    localparam int SYNC_N = 2;
    localparam int PRE_W  = 15;
    localparam int SEL_W  = $clog2(N_EVT);

    typedef enum logic [1:0] {
        SRC_BUS = 2'd0,
        SRC_SYS = 2'd1,
        SRC_LF  = 2'd2,
        SRC_HF  = 2'd3
    } src_e;

    typedef struct packed {
        logic [2:0]       rsv;
        logic             cap_en;
        logic [SEL_W-1:0] ev_sel;
        logic             ack_reload;
        src_e             src;
        logic             run;
        logic             periodic;
        logic             up;
        logic [1:0]       pre_sel;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(16'h000A);

    localparam logic [ADDR_W-1:0] A_LOAD  = 5'h00;
    localparam logic [ADDR_W-1:0] A_VALUE = 5'h04;
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] A_ACK   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CAP   = 5'h10;
    localparam logic [ADDR_W-1:0] A_STAT  = 5'h1C;

    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    return PRE_W'(0);
            2'd1:    return PRE_W'(15);
            2'd2:    return PRE_W'(255);
            default: return PRE_W'(32767);
        endcase
    endfunction

endpackage

// File: rtl/udt_tick_gen.sv
module udt_tick_gen
    import udt_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int SS = SYNC_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  src_e          src,
    input  logic [1:0]    pre_sel,
    input  logic [NS-1:0] ext_clk,
    output logic          step
);

    logic [NS-1:0]    rise;
    logic             tick;
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    for (genvar g = 0; g < NS; g++) begin : g_sync
        logic [SS-1:0] sh_q;
        logic          last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '0;
                last_q <= 1'b0;
            end else begin
                sh_q   <= {sh_q[SS-2:0], ext_clk[g]};
                last_q <= sh_q[SS-1];
            end
        end
        assign rise[g] = sh_q[SS-1] & ~last_q;
    end

    always_comb begin
        case (src)
            SRC_BUS: tick = 1'b1;
            SRC_SYS: tick = rise[0];
            SRC_LF:  tick = rise[1];
            default: tick = rise[NS-1];
        endcase
    end

    assign limit    = pre_limit(pre_sel);
    assign at_limit = (pre_q >= limit);
    assign step     = run & tick & at_limit;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= at_limit ? '0 : pre_q + 1'b1;
        end
    end

    // R6: steps never come back to back when the divider is above one
    p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (step && pre_sel != 2'd0) |=> !step);

endmodule

// File: rtl/udt_counter.sv
module udt_counter
    import udt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         up,
    input  logic         periodic,
    input  logic         reload_now,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         timeout
);

    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end  = up ? (cnt_q == {W{1'b1}}) : (cnt_q == '0);
    assign timeout = step & at_end;
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (reload_now) begin
            cnt_q <= load_val;
        end else if (step) begin
            if (at_end && periodic) cnt_q <= load_val;
            else if (up)            cnt_q <= cnt_q + 1'b1;
            else                    cnt_q <= cnt_q - 1'b1;
        end
    end

    p_down_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !up && !reload_now && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    p_up_step_r4: assert property (@(posedge clk) disable iff (rst)
        (step && up && !reload_now && cnt_q != {W{1'b1}}) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_periodic_reload_r5: assert property (@(posedge clk) disable iff (rst)
        (timeout && periodic && !reload_now) |=> cnt_q == $past(load_val));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!step && !reload_now) |=> $stable(cnt_q));

endmodule

// File: rtl/udt_capture.sv
module udt_capture
    import udt_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NE = N_EVT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [$clog2(NE)-1:0] sel,
    input  logic [NE-1:0]         events,
    input  logic [W-1:0]          cnt,
    input  logic                  rd_clr,
    output logic [W-1:0]          cap,
    output logic                  flag
);

    logic         fire;
    logic [W-1:0] cap_q;
    logic         flag_q;

    assign fire = en & events[sel];
    assign cap  = cap_q;
    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (fire) cap_q <= cnt;
            if (fire)        flag_q <= 1'b1;
            else if (rd_clr) flag_q <= 1'b0;
        end
    end

    p_capture_r11: assert property (@(posedge clk) disable iff (rst)
        (en && events[sel]) |=> (cap_q == $past(cnt)) && flag_q);

    p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !(en && events[sel])) |=> !flag_q);

endmodule

// File: rtl/udt_timer.sv
module udt_timer
    import udt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [N_SRC-1:0]  ext_clk,
    input  logic [N_EVT-1:0]  events,
    output logic              irq
);

    ctrl_t            ctrl_q, ctrl_n;
    logic [CNT_W-1:0] ld_q, pend_q, val1_q, val2_q, cnt, cap;
    logic             pend_v_q, sta_to_q, cap_flag, step, timeout;
    logic             wr, rd, ld_wr, ctrl_wr, ack_wr, cap_rd, reload_now;
    logic [15:0]      rdata_q;
    logic [1:0]       age_q;

    assign wr         = bus_en & bus_wr;
    assign rd         = bus_en & ~bus_wr;
    assign ld_wr      = wr & (bus_addr == A_LOAD);
    assign ctrl_wr    = wr & (bus_addr == A_CTRL);
    assign ack_wr     = wr & (bus_addr == A_ACK) & bus_wdata[0];
    assign cap_rd     = rd & (bus_addr == A_CAP);
    assign reload_now = ack_wr & ctrl_q.periodic & ctrl_q.ack_reload;

    always_comb begin
        ctrl_n     = ctrl_t'(bus_wdata);
        ctrl_n.rsv = '0;
    end

    udt_tick_gen i_tick (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.run),
        .restart (reload_now),
        .src     (ctrl_q.src),
        .pre_sel (ctrl_q.pre_sel),
        .ext_clk (ext_clk),
        .step    (step)
    );

    udt_counter i_cnt (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .up         (ctrl_q.up),
        .periodic   (ctrl_q.periodic),
        .reload_now (reload_now),
        .load_val   (ld_q),
        .cnt        (cnt),
        .timeout    (timeout)
    );

    udt_capture i_cap (
        .clk    (clk),
        .rst    (rst),
        .en     (ctrl_q.cap_en),
        .sel    (ctrl_q.ev_sel),
        .events (events),
        .cnt    (cnt),
        .rd_clr (cap_rd),
        .cap    (cap),
        .flag   (cap_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= CTRL_RST;
            ld_q     <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            sta_to_q <= 1'b0;
            val1_q   <= '0;
            val2_q   <= '0;
            age_q    <= '0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_n;
            if (timeout) begin
                if (ld_wr) begin
                    pend_q   <= bus_wdata;
                    pend_v_q <= 1'b1;
                end
            end else if (ld_wr) begin
                ld_q     <= bus_wdata;
                pend_v_q <= 1'b0;
            end else if (pend_v_q) begin
                ld_q     <= pend_q;
                pend_v_q <= 1'b0;
            end
            if (timeout)     sta_to_q <= 1'b1;
            else if (ack_wr) sta_to_q <= 1'b0;
            val1_q <= cnt;
            val2_q <= val1_q;
            if (age_q != 2'd2) age_q <= age_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            case (bus_addr)
                A_LOAD:  rdata_q <= ld_q;
                A_VALUE: rdata_q <= val2_q;
                A_CTRL:  rdata_q <= ctrl_q;
                A_CAP:   rdata_q <= cap;
                A_STAT:  rdata_q <= {14'b0, cap_flag, sta_to_q};
                default: rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = sta_to_q;

    p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
        timeout |=> irq);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !timeout) |=> !irq);

    p_defer_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (timeout && ld_wr) |=> $stable(ld_q));

    p_defer_apply_r10: assert property (@(posedge clk) disable iff (rst)
        (timeout && ld_wr) ##1 (!timeout && !ld_wr) |=> ld_q == $past(bus_wdata, 2));

    p_value_lag_r12: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> val2_q == $past(cnt, 2));

    p_ack_reload_r9: assert property (@(posedge clk) disable iff (rst)
        reload_now |=> cnt == $past(ld_q));

endmodule

// File: tb/test_udt_timer.sv
module test_udt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  ext_clk = '0;
    logic [15:0] events = '0;
    logic        irq;

    int    n_vec = 0, n_bad = 0;
    bit    running = 1'b0, ev_on = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    udt_timer i_udt_timer (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .events(events), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    logic [15:0] m_ld, m_cnt, m_v1, m_v2, m_cap, m_rd, m_pval, m_ctrl;
    logic        m_to, m_cf, m_pend;
    int          m_pre, lim;
    logic [2:0]  ms1, ms2, mp;
    logic        tick, stp, tmo, rel, fire, wr, rd, ldw, ackw;

    always @(posedge clk) begin
        if (rst) begin
            m_ld = 0; m_cnt = 0; m_v1 = 0; m_v2 = 0; m_cap = 0; m_rd = 0;
            m_pval = 0; m_ctrl = 16'h000A; m_to = 0; m_cf = 0; m_pend = 0;
            m_pre = 0; ms1 = 0; ms2 = 0; mp = 0;
        end else begin
            wr   = bus_en && bus_wr;
            rd   = bus_en && !bus_wr;
            ldw  = wr && bus_addr == 5'h00;
            ackw = wr && bus_addr == 5'h0C && bus_wdata[0];
            case (m_ctrl[6:5])
                2'd0: tick = 1;
                2'd1: tick = ms2[0] && !mp[0];
                2'd2: tick = ms2[1] && !mp[1];
                default: tick = ms2[2] && !mp[2];
            endcase
            lim  = (m_ctrl[1:0] == 0) ? 0 : (m_ctrl[1:0] == 1) ? 15 :
                   (m_ctrl[1:0] == 2) ? 255 : 32767;
            stp  = m_ctrl[4] && tick && (m_pre >= lim);
            tmo  = stp && (m_ctrl[2] ? (m_cnt == 16'hFFFF) : (m_cnt == 0));
            rel  = ackw && m_ctrl[3] && m_ctrl[7];
            fire = m_ctrl[12] && events[m_ctrl[11:8]];
            if (rd) begin
                case (bus_addr)
                    5'h00: m_rd = m_ld;
                    5'h04: m_rd = m_v2;
                    5'h08: m_rd = m_ctrl;
                    5'h10: m_rd = m_cap;
                    5'h1C: m_rd = {14'b0, m_cf, m_to};
                    default: m_rd = 0;
                endcase
            end
            if (fire) begin m_cap = m_cnt; m_cf = 1; end
            else if (rd && bus_addr == 5'h10) m_cf = 0;
            if (tmo) m_to = 1; else if (ackw) m_to = 0;
            m_v2 = m_v1; m_v1 = m_cnt;
            if (!m_ctrl[4] || rel) m_pre = 0;
            else if (tick) m_pre = (m_pre >= lim) ? 0 : m_pre + 1;
            if (rel) m_cnt = m_ld;
            else if (stp) begin
                if (tmo && m_ctrl[3]) m_cnt = m_ld;
                else if (m_ctrl[2])   m_cnt = m_cnt + 1;
                else                  m_cnt = m_cnt - 1;
            end
            if (tmo) begin
                if (ldw) begin m_pend = 1; m_pval = bus_wdata; end
            end else if (ldw) begin m_ld = bus_wdata; m_pend = 0; end
            else if (m_pend) begin m_ld = m_pval; m_pend = 0; end
            if (wr && bus_addr == 5'h08) m_ctrl = bus_wdata & 16'h1FFF;
            mp = ms2; ms2 = ms1; ms1 = ext_clk;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            n_vec++;
            if (bus_rdata !== m_rd || irq !== m_to) begin
                n_bad++;
                $display("FAIL %s: rdata %h irq %b, expected rdata %h irq %b",
                         cur_req, bus_rdata, irq, m_rd, m_to);
            end
        end
    end

    // background time bases and events
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            k++;
            if (k % 2 == 0) ext_clk[0] = ~ext_clk[0];
            if (k % 3 == 0) ext_clk[1] = ~ext_clk[1];
            if (k % 5 == 0) ext_clk[2] = ~ext_clk[2];
            if (ev_on) events = ($urandom % 3 == 0) ? ($urandom & 16'hFFFF) : 16'h0;
            else       events = 16'h0;
        end
    end

    // ---------------- stimulus ----------------
    task automatic bwrite(input logic [4:0] a, input logic [15:0] d);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic bread(input logic [4:0] a);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic chk_read(input logic [4:0] a, input logic [15:0] exp, input string req);
        bread(a);
        n_vec++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: offset %h read %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic watch_value(input int n);
        for (int i = 0; i < n; i++) begin
            bread(5'h04);
            if (i % 4 == 3) bread(5'h1C);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        running = 1;

        // R1: reset values
        cur_req = "R1";
        chk_read(5'h08, 16'h000A, "R1");
        chk_read(5'h00, 16'h0000, "R1");
        chk_read(5'h04, 16'h0000, "R1");
        chk_read(5'h10, 16'h0000, "R1");
        chk_read(5'h1C, 16'h0000, "R1");
        n_vec++;
        if (irq !== 1'b0) begin n_bad++; $display("FAIL R1: irq %b expected 0", irq); end

        // R2: map, access, reserved bits
        cur_req = "R2";
        bwrite(5'h00, 16'h1234);
        chk_read(5'h00, 16'h1234, "R2");
        bwrite(5'h08, 16'hE000);
        chk_read(5'h08, 16'h0000, "R2");
        chk_read(5'h0C, 16'h0000, "R2");
        chk_read(5'h14, 16'h0000, "R2");
        chk_read(5'h18, 16'h0000, "R2");

        // R3: free-running down from 0, first step is a run-out
        cur_req = "R3";
        bwrite(5'h00, 16'h0000);
        bwrite(5'h08, 16'h0010);
        @(negedge clk);
        n_vec++;
        if (irq !== 1'b1) begin n_bad++; $display("FAIL R3: irq %b expected 1", irq); end
        watch_value(12);
        cur_req = "R8";
        bwrite(5'h0C, 16'h0001);
        chk_read(5'h1C, 16'h0000, "R8");

        // R4: free-running up, wrap at 0xFFFF
        cur_req = "R4";
        bwrite(5'h08, 16'h0014);
        watch_value(10);
        bwrite(5'h0C, 16'h0001);

        // R5: periodic down, short period, ack colliding with run-outs
        cur_req = "R5";
        bwrite(5'h00, 16'h0005);
        bwrite(5'h08, 16'h0018);
        for (int i = 0; i < 10; i++) begin
            bread(5'h04);
            bwrite(5'h0C, 16'h0001);
            bread(5'h1C);
        end
        bwrite(5'h08, 16'h001C);
        cur_req = "R4";
        bwrite(5'h00, 16'hFFFA);
        watch_value(12);

        // R9: acknowledge reloads only with bit 7 set
        cur_req = "R9";
        bwrite(5'h00, 16'h0040);
        bwrite(5'h08, 16'h0098);
        idle(5);
        bwrite(5'h0C, 16'h0001);
        watch_value(6);
        bwrite(5'h08, 16'h0018);
        idle(3);
        bwrite(5'h0C, 16'h0001);
        watch_value(6);

        // R10: load writes colliding with run-outs
        cur_req = "R10";
        bwrite(5'h00, 16'h0002);
        for (int i = 0; i < 16; i++) begin
            bwrite(5'h00, 16'h0002 + (i % 3));
            bread(5'h00);
            bread(5'h04);
        end
        bwrite(5'h00, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            bwrite(5'h00, 16'h0003 + i);
            bread(5'h00);
        end

        // R6: prescaler and enable
        cur_req = "R6";
        bwrite(5'h00, 16'h0100);
        bwrite(5'h08, 16'h0011);
        watch_value(40);
        bwrite(5'h08, 16'h0012);
        idle(600);
        watch_value(4);
        bwrite(5'h08, 16'h0001);
        idle(50);
        watch_value(4);
        bwrite(5'h08, 16'h0013);
        idle(32766);
        watch_value(6);
        idle(32760);
        watch_value(6);

        // R7: external time bases
        cur_req = "R7";
        bwrite(5'h08, 16'h0034);
        watch_value(20);
        bwrite(5'h08, 16'h0054);
        watch_value(20);
        bwrite(5'h08, 16'h0070);
        watch_value(20);
        bwrite(5'h08, 16'h0071);
        idle(200);
        watch_value(6);

        // R11: event capture
        cur_req = "R11";
        bwrite(5'h08, 16'h0010);
        ev_on = 1;
        for (int s = 0; s < 16; s += 5) begin
            bwrite(5'h08, 16'h1014 | (s << 8));
            for (int i = 0; i < 12; i++) begin
                bread(5'h10);
                bread(5'h1C);
            end
        end
        bwrite(5'h08, 16'h0014);
        idle(8);
        for (int i = 0; i < 6; i++) bread(5'h10);
        ev_on = 0;
        bwrite(5'h08, 16'h1A14);
        bread(5'h10);
        bread(5'h1C);

        // R12: value lag during steady counting
        cur_req = "R12";
        bwrite(5'h08, 16'h0010);
        for (int i = 0; i < 20; i++) bread(5'h04);

        running = 0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule